// File: doc/BRIEF.md
# Content-Addressable Tag Memory

This block is a behavioural model of a small content-addressable array with 64 entries of 33-bit tags. A write port stores a tag into one addressed entry. A separate read port returns the contents of an addressed entry, so software-side logic or a test sequencer can inspect what is stored. A lookup port compares a 33-bit key against every entry at once and reports a 64-bit hit vector, with one bit per entry. More than one bit is set when several entries hold the same tag.

The hit vector and the read data are both registered, and each appears one clock after its request. A hold input freezes the registered hit vector, so a stalled downstream stage keeps seeing the result it has not yet consumed. A read is dropped in any cycle where a write is also requested. Entry contents are never cleared by reset. Only the registered outputs are cleared.

Top module: `tag_cam`

## Requirements
- R1: While reset is asserted, and after it, until the first lookup or read completes, `hit` is all zeros and `rd_data` is zero.
- R2: When `wr_en` is high at a rising edge, `wr_data` is stored in entry `wr_addr`. A later read of that address returns it one clock after the read is presented.
- R3: When `rd_en` and `wr_en` are both high in one cycle, no read occurs and `rd_data` keeps its previous value, whatever the addresses.
- R4: When `rd_en` is low, `rd_data` keeps its previous value.
- R5: With `lkup_en` high and `hold` low, `hit[i]` is 1 one clock later exactly for each entry i whose stored tag equals `lkup_key`. This can be zero, one or several bits.
- R6: With `lkup_en` low and `hold` low, `hit` is all zeros one clock later.
- R7: With `hold` high, `hit` keeps its previous value, whatever `lkup_en` and `lkup_key` are.
- R8: A lookup in the same cycle as a write compares against the entry's old contents. The newly written tag can match from the following cycle.
- R9: The comparison covers all 33 bits. A key that differs from a stored tag only in bit 32 does not hit that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write request |
| wr_addr | input | 6 | Entry written |
| wr_data | input | 33 | Tag written |
| rd_en | input | 1 | Read request |
| rd_addr | input | 6 | Entry read |
| rd_data | output | 33 | Registered read result |
| lkup_en | input | 1 | Lookup qualifier |
| lkup_key | input | 33 | Key compared against all entries |
| hold | input | 1 | Freezes the registered hit vector |
| hit | output | 64 | Registered per-entry match vector |

## Verification
The whole array is first filled with distinct tags. Lookups are then tried with four kinds of key:
- a unique key, which must give a one-hot vector;
- a key planted in two entries, which must give a two-hot vector;
- a key absent from the array, which must give zeros;
- a key one bit away from a stored tag, which shows whether the full width is compared.

Lookups that coincide with a write to the matching entry show whether the old or the new contents are compared. Held cycles with a changed key or with the enable dropped show whether the freeze really blocks updates. Reads interleaved with writes and idle cycles separate a true read from a stale hold.

// File: rtl/tag_cam_pkg.sv
package tag_cam_pkg;
  localparam int CAM_ENTRIES = 64;
  localparam int CAM_TAG_W   = 33;
  localparam int CAM_SYNC_STAGES = 2;
endpackage

// File: rtl/tag_cam_rst_sync.sv
module tag_cam_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tag_cam_store.sv
module tag_cam_store #(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 33,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [TAG_W-1:0]               wr_data,
  output logic [ENTRIES-1:0][TAG_W-1:0]  tags
);
  logic [ENTRIES-1:0] wr_sel;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    always_comb begin
      wr_sel[i] = wr_en && (wr_addr == ADDR_W'(i));
    end

    // contents are deliberately not reset
    always_ff @(posedge clk) begin
      if (wr_sel[i]) tags[i] <= wr_data;
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tags[$past(wr_addr)] == $past(wr_data)); // R2
endmodule

// File: rtl/tag_cam_read.sv
module tag_cam_read #(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 33,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rd_en,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              rd_addr,
  input  logic [ENTRIES-1:0][TAG_W-1:0]  tags,
  output logic [TAG_W-1:0]               rd_data
);
  logic             rd_fire;
  logic [TAG_W-1:0] rd_d;
  logic [TAG_W-1:0] rd_q;

  always_comb begin
    rd_fire = rd_en && !wr_en;
    rd_d    = tags[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_fire) rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  AST_RD_BLOCKED_BY_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $stable(rd_data)); // R3
  AST_RD_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R4
endmodule

// File: rtl/tag_cam_match.sv
module tag_cam_match #(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 33
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           lkup_en,
  input  logic [TAG_W-1:0]               lkup_key,
  input  logic                           hold,
  input  logic [ENTRIES-1:0][TAG_W-1:0]  tags,
  output logic [ENTRIES-1:0]             hit
);
  logic [ENTRIES-1:0] eq_vec;
  logic [ENTRIES-1:0] hit_d;
  logic [ENTRIES-1:0] hit_q;
  logic               hit_upd;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    always_comb begin
      eq_vec[i] = (tags[i] == lkup_key);
    end
  end

  always_comb begin
    hit_upd = !hold;
    hit_d   = lkup_en ? eq_vec : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hit_q <= '0;
    else if (hit_upd) hit_q <= hit_d;
  end

  assign hit = hit_q;

  AST_HIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(hit)); // R7
  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!lkup_en && !hold) |=> (hit == '0)); // R6
endmodule

// File: rtl/tag_cam.sv
module tag_cam #(
  parameter int ENTRIES = tag_cam_pkg::CAM_ENTRIES,
  parameter int TAG_W   = tag_cam_pkg::CAM_TAG_W,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [TAG_W-1:0]   wr_data,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [TAG_W-1:0]   rd_data,
  input  logic               lkup_en,
  input  logic [TAG_W-1:0]   lkup_key,
  input  logic               hold,
  output logic [ENTRIES-1:0] hit
);
  logic                          rst_int_n;
  logic [ENTRIES-1:0][TAG_W-1:0] tags;

  tag_cam_rst_sync #(.STAGES(tag_cam_pkg::CAM_SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  tag_cam_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tags(tags)
  );

  tag_cam_read #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_read (
    .clk(clk), .rst_n(rst_int_n), .rd_en(rd_en), .wr_en(wr_en),
    .rd_addr(rd_addr), .tags(tags), .rd_data(rd_data)
  );

  tag_cam_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
    .clk(clk), .rst_n(rst_int_n), .lkup_en(lkup_en), .lkup_key(lkup_key),
    .hold(hold), .tags(tags), .hit(hit)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_int_n |-> (hit == '0 && rd_data == '0)); // R1
endmodule

// File: tb/tag_cam_tb_top.sv
module tag_cam_tb_top;
  typedef struct {
    logic [63:0] hit;
    logic [32:0] rd;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [32:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic [32:0] rd_data;
  logic        lkup_en = 1'b0;
  logic [32:0] lkup_key = '0;
  logic        hold = 1'b0;
  logic [63:0] hit;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t sb_q[$];
  logic [32:0] mdl_mem [64];
  logic [63:0] mdl_hit = '0;
  logic [32:0] mdl_rd  = '0;

  always #10 clk = ~clk;

  tag_cam dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .lkup_en(lkup_en), .lkup_key(lkup_key), .hold(hold), .hit(hit)
  );

  function automatic logic [32:0] tag_of(input int i);
    return 33'(i * 32'h0101_0F07 + 32'h5A5A_0001);
  endfunction

  task automatic step(input bit we, input logic [5:0] wa, input logic [32:0] wd,
                      input bit re, input logic [5:0] ra,
                      input bit le, input logic [32:0] key, input bit hd,
                      input string req);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_addr = ra;
    lkup_en = le; lkup_key = key; hold = hd;
    if (!hd) begin
      mdl_hit = '0;
      if (le) for (int i = 0; i < 64; i++) mdl_hit[i] = (mdl_mem[i] == key);
    end
    if (re && !we) mdl_rd = mdl_mem[ra];
    if (we) mdl_mem[wa] = wd;
    e.hit = mdl_hit; e.rd = mdl_rd; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic idle(input string req);
    step(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b0, req);
  endtask

  // monitor: compares each registered result just after the edge that makes it
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        checks++;
        if (hit !== e.hit) begin
          fails++;
          $display("FAIL %s hit actual=%h expected=%h", e.req, hit, e.hit);
        end
        checks++;
        if (rd_data !== e.rd) begin
          fails++;
          $display("FAIL %s rd_data actual=%h expected=%h", e.req, rd_data, e.rd);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [32:0] dup;
    logic [32:0] fresh;
    repeat (3) @(negedge clk);
    checks++;
    if (hit !== '0 || rd_data !== '0) begin
      fails++;
      $display("FAIL R1 reset hit=%h rd=%h expected=0 0", hit, rd_data);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (hit !== '0 || rd_data !== '0) begin
      fails++;
      $display("FAIL R1 after release hit=%h rd=%h expected=0 0", hit, rd_data);
    end
    // fill every entry; lookup disabled throughout (R6)
    for (int i = 0; i < 64; i++) step(1'b1, 6'(i), tag_of(i), 1'b0, '0, 1'b0, '0, 1'b0, "R2_R6");
    // reads of several entries (R2)
    step(1'b0, '0, '0, 1'b1, 6'd0,  1'b0, '0, 1'b0, "R2");
    step(1'b0, '0, '0, 1'b1, 6'd63, 1'b0, '0, 1'b0, "R2");
    step(1'b0, '0, '0, 1'b1, 6'd17, 1'b0, '0, 1'b0, "R2");
    // idle: rd_data must hold (R4)
    idle("R4"); idle("R4");
    // read during write is dropped (R3)
    step(1'b1, 6'd30, 33'h1_2345_6789, 1'b1, 6'd5, 1'b0, '0, 1'b0, "R3");
    step(1'b0, '0, '0, 1'b1, 6'd30, 1'b0, '0, 1'b0, "R2");
    // unique lookup: one-hot (R5)
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, tag_of(9), 1'b0, "R5");
    // plant duplicate tag in two entries, then multi-hot (R5)
    dup = 33'h1_DEAD_BEEF;
    step(1'b1, 6'd5,  dup, 1'b0, '0, 1'b0, '0, 1'b0, "R2");
    step(1'b1, 6'd40, dup, 1'b0, '0, 1'b0, '0, 1'b0, "R2");
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, dup, 1'b0, "R5");
    // absent key: no hits (R5)
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, 33'h0_7777_7777, 1'b0, "R5");
    // bit-32 difference must not match (R9)
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, dup ^ 33'h1_0000_0000, 1'b0, "R9");
    // hold: result frozen against new key and dropped enable (R7)
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, dup, 1'b0, "R5");
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, tag_of(3), 1'b1, "R7");
    step(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b1, "R7");
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, tag_of(3), 1'b0, "R5");
    // enable low releases to zeros (R6)
    step(1'b0, '0, '0, 1'b0, '0, 1'b0, tag_of(3), 1'b0, "R6");
    // write and lookup in one cycle: old contents compared (R8)
    fresh = 33'h0_CAFE_F00D;
    step(1'b1, 6'd12, fresh, 1'b0, '0, 1'b1, fresh, 1'b0, "R8");
    step(1'b0, '0, '0, 1'b1, 6'd12, 1'b1, fresh, 1'b0, "R8");
    // old tag of entry 12 no longer hits
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, tag_of(12), 1'b0, "R8");
    idle("R6"); idle("R4");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule